// File: doc/BRIEF.md
# Framed serial sample input port

This block is the serial front end of one transmit channel. A DSP sends baseband sample pairs to it over a serial data line. The block turns each frame of serial bits into an I word and a Q word and presents the pair with a one-cycle valid strobe. Filtering and the rest of the datapath sit downstream.

The serial clock can come from either side of the link. As clock master, the block divides the system clock to make the serial clock. As clock slave, it synchronizes an external serial clock and captures data on its falling edge. A frame can start in one of three ways: on a data request that the block issues itself at the sample rate, on an external frame pin, or on the frame-end strobe of the neighbouring channel. The frame output pin can carry either the data request or a frame-end strobe, so two devices can be chained.

Sleep, the divider, the sample period, the frame length and the mode bits are static configuration. Sleep also serves as the channel reset.

Top module: `serial_sample_port`

## Requirements
- R1: In master mode with the legacy bit clear, the serial clock period is N = cfg_div+1 system clocks. sclk_o is high for the first ceil(N/2) clocks of each period. A bit-capture instant (a "tick") is the system clock edge that starts each period.
- R2: In master mode with cfg_legacy set, N = 2*(cfg_div+1). The high phase and the ticks follow the same rule as R1.
- R3: While cfg_sleep is high, the block gives sclk_o, sdfo, frame_end and word_valid low. On the first system clock edge with cfg_sleep low, sclk_o rises, and that edge is tick 0.
- R4: Number the awake clock edges from 1, starting with the first edge after sleep is released. The j-th data request falls on the first tick at which this count has reached j*cfg_period. Request spacing therefore alternates between whole serial periods so that the average matches the sample period, and the first request is held off by one sample period after wake-up.
- R5: With cfg_fo_is_end clear, sdfo goes high at a request tick and stays high for exactly one serial clock period.
- R6: A frame starts at a tick on which its source is high. The next L = cfg_frame_len ticks (L even, 2 to 32) each capture one bit, MSB first. The first L/2 bits form i_word and the last L/2 bits form q_word, both right-justified.
- R7: word_valid is high for one system clock, right after the edge that captures the last bit. i_word and q_word change only together with that pulse.
- R8: frame_end is high for one serial clock period starting at the last-bit tick. With cfg_fo_is_end set, sdfo carries this strobe in place of the request.
- R9: With cfg_ext_frame clear, frames start on the internal request. With it set, frames start on sdfi when cfg_frame_from_prev is 0, or on prev_frame_end when it is 1. The source that is not selected has no effect. sdfi and prev_frame_end are sampled at ticks.
- R10: A frame-start strobe that arrives while a frame is still being received is ignored.
- R11: In slave mode, sclk_i passes through a two-stage synchronizer and ticks occur on its falling edges. sdin and sdfi are delayed by the same amount, and sclk_o stays low. sclk_i must be no faster than half the system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sleep | input | 1 | Channel sleep and channel reset |
| cfg_slave | input | 1 | 1 = serial clock taken from sclk_i |
| cfg_legacy | input | 1 | 1 = master divide by 2*(div+1) |
| cfg_div | input | DIV_W | Serial clock divider setting |
| cfg_period | input | PER_W | Sample period in system clocks |
| cfg_frame_len | input | LEN_W | Bits per frame, even, 2..MAX_BITS |
| cfg_ext_frame | input | 1 | 1 = external frame start |
| cfg_frame_from_prev | input | 1 | External source: 0 = sdfi, 1 = prev_frame_end |
| cfg_fo_is_end | input | 1 | sdfo carries frame end instead of request |
| sclk_i | input | 1 | External serial clock (slave mode) |
| sclk_o | output | 1 | Generated serial clock (master mode) |
| sdin | input | 1 | Serial data |
| sdfi | input | 1 | External frame-start pin |
| prev_frame_end | input | 1 | Frame-end strobe from the neighbouring channel |
| sdfo | output | 1 | Frame output: request or frame end |
| frame_end | output | 1 | Frame-end strobe toward the next channel |
| i_word | output | MAX_BITS/2 | Received I word |
| q_word | output | MAX_BITS/2 | Received Q word |
| word_valid | output | 1 | One-cycle strobe for a new word pair |

## Verification
The bench builds the block with its default parameters: a 5-bit divider, 32-bit maximum frames and a 12-bit sample period. These values bring divide ratios of 1, 3 and 4 within reach, as well as full-length 32-bit frames and sample periods that are not whole multiples of the serial period. The self-framed runs check every cycle against request positions computed as rounded-up multiples of the divide ratio, so the stretched request periods and the first-request delay are covered. Separate runs cover both external frame sources with a decoy strobe on the unselected source and a strobe during a busy frame. A further run uses a slow external serial clock in slave mode.

// File: rtl/serial_sample_port.sv
module serial_sample_port #(
  parameter int DIV_W    = 5,
  parameter int LEN_W    = 6,
  parameter int MAX_BITS = 32,
  parameter int PER_W    = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_sleep,
  input  logic                    cfg_slave,
  input  logic                    cfg_legacy,
  input  logic [DIV_W-1:0]        cfg_div,
  input  logic [PER_W-1:0]        cfg_period,
  input  logic [LEN_W-1:0]        cfg_frame_len,
  input  logic                    cfg_ext_frame,
  input  logic                    cfg_frame_from_prev,
  input  logic                    cfg_fo_is_end,
  input  logic                    sclk_i,
  output logic                    sclk_o,
  input  logic                    sdin,
  input  logic                    sdfi,
  input  logic                    prev_frame_end,
  output logic                    sdfo,
  output logic                    frame_end,
  output logic [MAX_BITS/2-1:0]   i_word,
  output logic [MAX_BITS/2-1:0]   q_word,
  output logic                    word_valid
);
  localparam int WORD_W = MAX_BITS / 2;
  localparam int CNT_W  = DIV_W + 2;
  localparam int ACC_W  = PER_W + 1;

  // master serial clock divider (R1, R2, R3)
  logic             run;
  logic [CNT_W-1:0] cnt, base, ndiv, hi_len;
  logic             m_tick;

  assign base   = CNT_W'(cfg_div) + CNT_W'(1);
  assign ndiv   = cfg_legacy ? (base << 1) : base;
  assign hi_len = (ndiv + CNT_W'(1)) >> 1;
  assign m_tick = !run || (cnt == ndiv - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (cfg_sleep) begin
      run <= 1'b0;
      cnt <= '0;
    end else begin
      run <= 1'b1;
      cnt <= m_tick ? '0 : cnt + CNT_W'(1);
    end

  assign sclk_o = run && !cfg_slave && (cnt < hi_len);

  // slave clock synchronizer with matched data delay (R11)
  logic [2:0] sck_sy;
  logic [1:0] din_sy, fin_sy;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_sy <= '0;
      din_sy <= '0;
      fin_sy <= '0;
    end else begin
      sck_sy <= {sck_sy[1:0], sclk_i};
      din_sy <= {din_sy[0], sdin};
      fin_sy <= {fin_sy[0], sdfi};
    end

  logic tick, bit_in, fi_in;
  assign tick   = !cfg_sleep && (cfg_slave ? (sck_sy[2] && !sck_sy[1]) : m_tick);
  assign bit_in = cfg_slave ? din_sy[1] : sdin;
  assign fi_in  = cfg_slave ? fin_sy[1] : sdfi;

  // rate-tracking request generator (R4)
  logic [ACC_W-1:0] acc, acc_inc;
  logic             req;
  assign acc_inc = (&acc) ? acc : acc + ACC_W'(1);
  assign req     = tick && (acc_inc >= ACC_W'(cfg_period));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          acc <= '0;
    else if (cfg_sleep)  acc <= '0;
    else if (req)        acc <= acc_inc - ACC_W'(cfg_period);
    else                 acc <= acc_inc;

  // frame reception (R6, R9, R10)
  logic                busy, start_src, start, last;
  logic [LEN_W-1:0]    bcnt, half;
  logic [MAX_BITS-1:0] shreg, full, mask;

  assign start_src = !cfg_ext_frame ? req : (cfg_frame_from_prev ? prev_frame_end : fi_in);
  assign start     = tick && !busy && start_src;
  assign last      = tick && busy && (bcnt == cfg_frame_len - LEN_W'(1));
  assign full      = {shreg[MAX_BITS-2:0], bit_in};
  assign half      = cfg_frame_len >> 1;
  assign mask      = (MAX_BITS'(1) << half) - MAX_BITS'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy  <= 1'b0;
      bcnt  <= '0;
      shreg <= '0;
    end else if (cfg_sleep) begin
      busy  <= 1'b0;
      bcnt  <= '0;
    end else if (tick) begin
      if (busy) begin
        shreg <= full;
        bcnt  <= bcnt + LEN_W'(1);
        if (last) busy <= 1'b0;
      end else if (start) begin
        busy <= 1'b1;
        bcnt <= '0;
      end
    end

  // outputs (R5, R7, R8)
  logic req_q, end_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      req_q      <= 1'b0;
      end_q      <= 1'b0;
      word_valid <= 1'b0;
      i_word     <= '0;
      q_word     <= '0;
    end else if (cfg_sleep) begin
      req_q      <= 1'b0;
      end_q      <= 1'b0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= last;
      if (tick) begin
        req_q <= req;
        end_q <= last;
      end
      if (last) begin
        i_word <= WORD_W'((full >> half) & mask);
        q_word <= WORD_W'(full & mask);
      end
    end

  assign sdfo      = cfg_fo_is_end ? end_q : req_q;
  assign frame_end = end_q;
endmodule

module serial_sample_port_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_sleep,
  input logic              cfg_slave,
  input logic              sclk_o,
  input logic              sdfo,
  input logic              frame_end,
  input logic              word_valid,
  input logic [WORD_W-1:0] i_word,
  input logic [WORD_W-1:0] q_word
);
  p_sleep_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sleep |=> (!sclk_o && !sdfo && !frame_end && !word_valid));

  p_wake_clock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_slave && $fell(cfg_sleep)) |=> sclk_o);

  p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  p_words_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> ($stable(i_word) && $stable(q_word)));
endmodule

bind serial_sample_port serial_sample_port_chk #(.WORD_W(MAX_BITS/2)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_sleep(cfg_sleep), .cfg_slave(cfg_slave),
  .sclk_o(sclk_o), .sdfo(sdfo), .frame_end(frame_end), .word_valid(word_valid),
  .i_word(i_word), .q_word(q_word)
);

// File: tb/serial_sample_port_tb.sv
module serial_sample_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_sleep = 1'b1, cfg_slave = 1'b0, cfg_legacy = 1'b0;
  logic [4:0]  cfg_div = '0;
  logic [11:0] cfg_period = 12'd40;
  logic [5:0]  cfg_frame_len = 6'd8;
  logic cfg_ext_frame = 1'b0, cfg_frame_from_prev = 1'b0, cfg_fo_is_end = 1'b0;
  logic sclk_i = 1'b0, sdin = 1'b0, sdfi = 1'b0, prev_frame_end = 1'b0;
  logic sclk_o, sdfo, frame_end, word_valid;
  logic [15:0] i_word, q_word;

  int checks = 0;
  int failures = 0;
  int vcount = 0;
  logic [15:0] last_i, last_q;

  always #2 clk = ~clk;

  serial_sample_port dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_sleep(cfg_sleep), .cfg_slave(cfg_slave),
    .cfg_legacy(cfg_legacy), .cfg_div(cfg_div), .cfg_period(cfg_period),
    .cfg_frame_len(cfg_frame_len), .cfg_ext_frame(cfg_ext_frame),
    .cfg_frame_from_prev(cfg_frame_from_prev), .cfg_fo_is_end(cfg_fo_is_end),
    .sclk_i(sclk_i), .sclk_o(sclk_o), .sdin(sdin), .sdfi(sdfi),
    .prev_frame_end(prev_frame_end), .sdfo(sdfo), .frame_end(frame_end),
    .i_word(i_word), .q_word(q_word), .word_valid(word_valid)
  );

  always @(negedge clk)
    if (word_valid) begin
      vcount <= vcount + 1;
      last_i <= i_word;
      last_q <= q_word;
    end

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic longint gen_word(input int fr, input int len);
    longint w = (longint'(fr) * 40503 + 64'h5A5A1234) & 64'hFFFF_FFFF;
    if (len < 32) w = w & ((longint'(1) << len) - 1);
    return w;
  endfunction

  task automatic go_sleep();
    @(negedge clk);
    cfg_sleep = 1'b1;
    repeat (3) @(negedge clk);
    check("R3 sclk_o low in sleep", sclk_o, 0);
    check("R3 sdfo low in sleep", sdfo, 0);
    check("R3 frame_end low in sleep", frame_end, 0);
  endtask

  // self-framed master run, checked every cycle (R1 R2 R3 R4 R5 R6 R7 R8)
  task automatic run_self(input int div, input bit leg, input int per,
                          input int len, input bit fo_end, input int nreq);
    int n, hi, j, fs, lastr, fr, total, rj, k, vfr;
    longint word, vword;
    n = leg ? 2 * (div + 1) : div + 1;
    hi = (n + 1) / 2;
    go_sleep();
    cfg_slave = 0; cfg_legacy = leg; cfg_div = 5'(div); cfg_period = 12'(per);
    cfg_frame_len = 6'(len); cfg_ext_frame = 0; cfg_fo_is_end = fo_end;
    j = 1; fs = -1; lastr = -1; fr = 0; word = 0; vword = 0; vfr = 0;
    total = ((nreq * per - 1 + n - 1) / n) * n + len * n + n + 2;
    cfg_sleep = 1'b0;
    for (int e = 0; e < total; e++) begin
      rj = ((j * per - 1 + n - 1) / n) * n;
      if (e == rj && j <= nreq) begin
        if (fs >= 0) begin vword = word; vfr = fs; end
        fs = e; lastr = e; j++; fr++; word = gen_word(fr + per, len);
      end
      sdin = 1'b0;
      if (fs >= 0 && e > fs && (e - fs) % n == 0) begin
        k = (e - fs) / n;
        if (k <= len) sdin = word[len - k];
      end
      @(negedge clk);
      check(leg ? "R2 sclk_o phase" : "R1 sclk_o phase", sclk_o, (e % n) < hi);
      if (fo_end)
        check("R8 sdfo frame-end window", sdfo,
              fs >= 0 && e >= fs + len * n && e < fs + len * n + n);
      else
        check("R4 R5 sdfo request window", sdfo, lastr >= 0 && e - lastr < n);
      check("R8 frame_end window", frame_end,
            fs >= 0 && e >= fs + len * n && e < fs + len * n + n);
      check("R7 word_valid timing", word_valid, fs >= 0 && e == fs + len * n);
      if (fs >= 0 && e == fs + len * n) begin
        check("R6 i_word", i_word, (word >> (len / 2)) & ((longint'(1) << (len / 2)) - 1));
        check("R6 q_word", q_word, word & ((longint'(1) << (len / 2)) - 1));
      end
    end
    if (vfr < 0) check("R7 unreachable", 0, 1);
  endtask

  // externally framed master run (R9 R10)
  task automatic run_ext(input bit from_prev);
    int n, len, fr, fs;
    longint word;
    logic act_s, dec_s;
    n = 2; len = 8;
    go_sleep();
    cfg_slave = 0; cfg_legacy = 0; cfg_div = 5'd1; cfg_period = 12'd3000;
    cfg_frame_len = 6'(len); cfg_ext_frame = 1; cfg_frame_from_prev = from_prev;
    cfg_fo_is_end = 0;
    fr = 0; fs = -1; word = 0;
    cfg_sleep = 1'b0;
    for (int e = 0; e < 80; e++) begin
      act_s = (e >= 10 && e < 12) || (e >= 40 && e < 42) || (e >= 46 && e < 48);
      dec_s = (e >= 30 && e < 32) || (e >= 60 && e < 62);
      if (e == 10 || e == 40) begin fs = e; fr++; word = gen_word(fr * 7 + from_prev, len); end
      if (from_prev) begin prev_frame_end = act_s; sdfi = dec_s; end
      else begin sdfi = act_s; prev_frame_end = dec_s; end
      sdin = 1'b0;
      if (fs >= 0 && e > fs && (e - fs) % n == 0 && (e - fs) / n <= len)
        sdin = word[len - (e - fs) / n];
      @(negedge clk);
      check(from_prev ? "R9 R10 valid with prev source" : "R9 R10 valid with pin source",
            word_valid, e == 10 + len * n || e == 40 + len * n);
      if (fs >= 0 && e == fs + len * n) begin
        check("R9 i_word external", i_word, word >> 4);
        check("R9 q_word external", q_word, word & 15);
      end
    end
    sdfi = 0; prev_frame_end = 0;
  endtask

  task automatic sck_cycle(input int h, input bit fi, input bit d);
    @(negedge clk);
    sclk_i = 1'b1; sdfi = fi; sdin = d;
    repeat (h) @(negedge clk);
    sclk_i = 1'b0;
    repeat (h - 1) @(negedge clk);
  endtask

  // slave mode (R11)
  task automatic run_slave();
    int len, v0;
    longint word;
    len = 6;
    go_sleep();
    cfg_slave = 1; cfg_ext_frame = 1; cfg_frame_from_prev = 0; cfg_frame_len = 6'(len);
    cfg_period = 12'd4000; cfg_fo_is_end = 0;
    cfg_sleep = 1'b0;
    for (int f = 0; f < 3; f++) begin
      word = gen_word(f + 91, len);
      v0 = vcount;
      sck_cycle(3, 1, 0);
      for (int k = 1; k <= len; k++) begin
        sck_cycle(3, k == 3, word[len - k]);
        check("R11 sclk_o low in slave", sclk_o, 0);
      end
      sck_cycle(3, 0, 0);
      sck_cycle(3, 0, 0);
      check("R11 one word per slave frame", vcount - v0, 1);
      check("R11 slave i_word", last_i, word >> 3);
      check("R11 slave q_word", last_q, word & 7);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R3 reset sclk_o", sclk_o, 0);
    check("R3 reset word_valid", word_valid, 0);
    rst_n = 1'b1;
    run_self(2, 0, 20, 4, 0, 6);   // N=3, stretched request periods
    run_self(0, 0, 37, 32, 0, 4);  // N=1, full-length frame
    run_self(1, 1, 45, 8, 0, 4);   // legacy N=4
    run_self(2, 0, 23, 6, 1, 4);   // sdfo as frame end
    run_ext(0);
    run_ext(1);
    run_slave();
    go_sleep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule